// File: doc/BRIEF.md
# Mailbox Request Engine

This block sends one command at a time through an eight-word shared mailbox and waits for the reply. There are two commands. The establish command carries four queue base addresses, a 16-bit interrupt vector index and a reset flag. The destroy command carries only the reset flag.

When a command is accepted, the engine first checks its arguments. It then polls the mailbox header word until the requester owns the mailbox. Next it packs the request and writes it out word by word. Finally it polls the header again until the reply arrives or the poll budget is used up. It ends with a one-cycle done pulse and a 2-bit result code: 0 success, 1 invalid argument, 2 timeout, 3 protocol error.

The mailbox storage sits outside the block. The engine reaches it through single-word read and write strobes. A read strobe returns data on `mb_rdata` one clock later. The time between polls is a parameter counted in clock cycles.

Top module: `mbx_req_engine`

## Requirements
- R1: The engine reads only word 7. Before writing a request, it polls word 7 until bit 31 is 0, which means the requester owns the mailbox.
- R2: An establish command is rejected when any address has a nonzero value in bits [11:0] or when the vector index has a nonzero value in bits [31:16]. A rejected command gives result 1, with no mailbox read and no mailbox write. A destroy command ignores the address and vector inputs.
- R3: Each page frame is the address shifted right by 12, which gives 52 bits. The low 48 bits of the frames for EQ, CQ, RQ and SQ fill bytes 0 to 23 in that order. The layout is little-endian, with word k holding bytes 4k to 4k+3.
- R4: Bytes 24 and 25 hold the top four bits of each frame. The nibble for frame i sits at bits [4i+3:4i], in the order EQ, CQ, RQ, SQ. Bytes 26 and 27 hold the vector index.
- R5: The request header is word 7, with these fields:
  - type in bits [2:0]: 1 for establish, 2 for destroy
  - version in bits [5:3]: 0
  - direction in bit 7: 0
  - status in bits [15:8]: 0
  - reset flag in bit 24
  - bit 31: 0
- R6: An establish command writes words 0 to 7, one per cycle, in ascending order. The header word is the last write.
- R7: A destroy command writes only word 7, once.
- R8: Polling takes at most POLL_LIMIT samples of word 7, spaced POLL_GAP cycles apart. If bit 31 stays 1 for all of them, the result is 2. This holds both before sending and while waiting for the reply.
- R9: If the reset flag was set, a reply read of 0xFFFFFFFF gives result 0 at once. If the reset flag was not set, that value counts as the mailbox still being owned by the other side.
- R10: Once bit 31 of word 7 reads 0 after the request, the reply is checked. It passes, with result 0, only if all four of these hold:
  - its type equals the request type
  - its version is not greater than the request version
  - its direction bit is 1
  - its status byte is 0

  Any other reply gives result 3.
- R11: `done` is high for exactly one cycle per command, with `result` valid in that cycle. `busy` is high from acceptance until done. A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_kind | input | 1 | 0 establish, 1 destroy |
| cmd_reset | input | 1 | Reset flag carried in the header |
| eq_addr | input | 64 | EQ base address |
| cq_addr | input | 64 | CQ base address |
| rq_addr | input | 64 | RQ base address |
| sq_addr | input | 64 | SQ base address |
| vec_idx | input | 32 | Interrupt vector index |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 bad argument, 2 timeout, 3 protocol error |
| mb_rd_en | output | 1 | Mailbox read strobe |
| mb_wr_en | output | 1 | Mailbox write strobe |
| mb_addr | output | 3 | Mailbox word index |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, one cycle after the read strobe |

## Verification
The bench sends establish commands with random page frames whose top nibbles are nonzero.

- If a low and high frame part were split at the wrong bit, or the nibbles were placed in the wrong order, the written words would not match the bench's byte-built image.
- The bench sends replies with a wrong type, a newer version, a request direction and a nonzero status. An engine that skipped any of these checks would report success where result 3 is due.
- The bench sends an all-ones reply both with and without the reset flag. This catches an engine that takes the shortcut without the flag, which would finish early, or never takes it, which would time out.
- Stalls before sending and before the reply show whether the read count stops at the poll limit.
- A misaligned address and an oversized vector show whether a rejected command still touches the mailbox.

// File: rtl/mbx_req_pkg.sv
package mbx_req_pkg;

    localparam int MB_WORDS   = 8;
    localparam int HDR_WORD   = 7;
    localparam int PAGE_SHIFT = 12;
    localparam int FRAME_W    = 52;
    localparam int LOW_W      = 48;
    localparam int NUM_Q      = 4;
    localparam int IMG_W      = MB_WORDS * 32;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_BADARG  = 2'd1,
        RES_TIMEOUT = 2'd2,
        RES_PROTO   = 2'd3
    } res_t;

    typedef enum logic {
        CMD_EST = 1'b0,
        CMD_DES = 1'b1
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE, S_OWN_RD, S_OWN_CHK, S_OWN_GAP,
        S_SEND, S_RSP_RD, S_RSP_CHK, S_RSP_GAP
    } state_t;

    localparam logic [2:0] TYPE_EST = 3'd1;
    localparam logic [2:0] TYPE_DES = 3'd2;
    localparam logic [2:0] VER_EST  = 3'd0;
    localparam logic [2:0] VER_DES  = 3'd0;

    typedef struct packed {
        logic       owner;
        logic [5:0] rsv3;
        logic       rst_flag;
        logic [7:0] rsv2;
        logic [7:0] status;
        logic       dir;
        logic       rsv1;
        logic [2:0] ver;
        logic [2:0] typ;
    } hdr_t;

    typedef struct packed {
        cmd_t                  kind;
        logic                  rst_flag;
        logic [NUM_Q-1:0][63:0] addr;
        logic [15:0]           vec;
    } cmd_q_t;

    function automatic logic [2:0] type_of(cmd_t k);
        return (k == CMD_EST) ? TYPE_EST : TYPE_DES;
    endfunction

    function automatic logic [2:0] ver_of(cmd_t k);
        return (k == CMD_EST) ? VER_EST : VER_DES;
    endfunction

    function automatic hdr_t req_hdr(cmd_t k, logic r);
        hdr_t h;
        h          = '0;
        h.typ      = type_of(k);
        h.ver      = ver_of(k);
        h.dir      = 1'b0;
        h.rst_flag = r;
        return h;
    endfunction

endpackage

// File: rtl/mbx_image_pack.sv
module mbx_image_pack
    import mbx_req_pkg::*;
(
    input  cmd_q_t                  cq,
    output logic [IMG_W-1:0]        image
);
    localparam int HI_W = FRAME_W - LOW_W;

    logic [NUM_Q-1:0][LOW_W-1:0] lo_part;
    logic [NUM_Q-1:0][HI_W-1:0]  hi_part;

    for (genvar i = 0; i < NUM_Q; i++) begin : g_frame
        logic [FRAME_W-1:0] frame;
        assign frame      = cq.addr[i][63:PAGE_SHIFT];
        assign lo_part[i] = frame[LOW_W-1:0];
        assign hi_part[i] = frame[FRAME_W-1:LOW_W];
    end

    always_comb begin
        image = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            image[LOW_W*i +: LOW_W]               = lo_part[i];
            image[LOW_W*NUM_Q + HI_W*i +: HI_W]   = hi_part[i];
        end
        image[LOW_W*NUM_Q + 16 +: 16]             = cq.vec;
        image[HDR_WORD*32 +: 32]                  = req_hdr(cq.kind, cq.rst_flag);
    end
endmodule

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
    parameter int POLL_LIMIT = 20000,
    parameter int POLL_GAP   = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic smp,
    input  logic gap_ld,
    output logic last_smp,
    output logic gap_zero
);
    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam int GW = $clog2(POLL_GAP + 1);

    logic [CW-1:0] smp_cnt;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)   smp_cnt <= '0;
        else if (smp)     smp_cnt <= smp_cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)                 gap_cnt <= '0;
        else if (gap_ld)         gap_cnt <= GW'(POLL_GAP - 1);
        else if (gap_cnt != '0)  gap_cnt <= gap_cnt - GW'(1);
    end

    assign last_smp = (smp_cnt == CW'(POLL_LIMIT - 1));
    assign gap_zero = (gap_cnt == '0);
endmodule

// File: rtl/mbx_reply_judge.sv
module mbx_reply_judge
    import mbx_req_pkg::*;
(
    input  logic [31:0] reply,
    input  logic [2:0]  exp_type,
    input  logic [2:0]  exp_ver,
    output logic        pass
);
    hdr_t h;
    assign h    = hdr_t'(reply);
    assign pass = (h.typ == exp_type) && (h.ver <= exp_ver)
                  && h.dir && (h.status == 8'd0);
endmodule

// File: rtl/mbx_req_engine.sv
module mbx_req_engine
    import mbx_req_pkg::*;
#(
    parameter int POLL_LIMIT = 20000,
    parameter int POLL_GAP   = 50000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic        cmd_kind,
    input  logic        cmd_reset,
    input  logic [63:0] eq_addr,
    input  logic [63:0] cq_addr,
    input  logic [63:0] rq_addr,
    input  logic [63:0] sq_addr,
    input  logic [31:0] vec_idx,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result,
    output logic        mb_rd_en,
    output logic        mb_wr_en,
    output logic [2:0]  mb_addr,
    output logic [31:0] mb_wdata,
    input  logic [31:0] mb_rdata
);
    state_t           state;
    cmd_q_t           cq;
    logic [2:0]       widx;
    logic             done_q;
    res_t             res_q;
    logic [IMG_W-1:0] image;
    logic             t_clr, t_smp, t_gap_ld, last_smp, gap_zero, rsp_pass;
    logic             arg_bad, owned, rst_hit;

    mbx_image_pack u_pack (.cq(cq), .image(image));

    mbx_poll_timer #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_timer (
        .clk(clk), .rst(rst), .clr(t_clr), .smp(t_smp), .gap_ld(t_gap_ld),
        .last_smp(last_smp), .gap_zero(gap_zero)
    );

    mbx_reply_judge u_judge (
        .reply(mb_rdata), .exp_type(type_of(cq.kind)),
        .exp_ver(ver_of(cq.kind)), .pass(rsp_pass)
    );

    always_comb begin
        arg_bad = (cmd_kind == CMD_EST) &&
                  ((eq_addr[PAGE_SHIFT-1:0] != '0) || (cq_addr[PAGE_SHIFT-1:0] != '0) ||
                   (rq_addr[PAGE_SHIFT-1:0] != '0) || (sq_addr[PAGE_SHIFT-1:0] != '0) ||
                   (vec_idx[31:16] != 16'd0));
        owned    = !mb_rdata[31];
        rst_hit  = cq.rst_flag && (mb_rdata == 32'hFFFF_FFFF);
        t_clr    = (state == S_IDLE) || (state == S_SEND);
        t_smp    = (state == S_OWN_CHK) || (state == S_RSP_CHK);
        t_gap_ld = t_smp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cq     <= '0;
            widx   <= '0;
            done_q <= 1'b0;
            res_q  <= RES_OK;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: if (cmd_valid) begin
                    if (arg_bad) begin
                        done_q <= 1'b1;
                        res_q  <= RES_BADARG;
                    end else begin
                        cq.kind     <= cmd_t'(cmd_kind);
                        cq.rst_flag <= cmd_reset;
                        cq.addr     <= {sq_addr, rq_addr, cq_addr, eq_addr};
                        cq.vec      <= vec_idx[15:0];
                        state       <= S_OWN_RD;
                    end
                end
                S_OWN_RD: state <= S_OWN_CHK;
                S_OWN_CHK: begin
                    if (owned) begin
                        state <= S_SEND;
                        widx  <= (cq.kind == CMD_DES) ? 3'(HDR_WORD) : 3'd0;
                    end else if (last_smp) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                        res_q  <= RES_TIMEOUT;
                    end else begin
                        state <= S_OWN_GAP;
                    end
                end
                S_OWN_GAP: if (gap_zero) state <= S_OWN_RD;
                S_SEND: begin
                    if (widx == 3'(HDR_WORD)) state <= S_RSP_RD;
                    else                      widx  <= widx + 3'd1;
                end
                S_RSP_RD: state <= S_RSP_CHK;
                S_RSP_CHK: begin
                    if (rst_hit) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                        res_q  <= RES_OK;
                    end else if (owned) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                        res_q  <= rsp_pass ? RES_OK : RES_PROTO;
                    end else if (last_smp) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                        res_q  <= RES_TIMEOUT;
                    end else begin
                        state <= S_RSP_GAP;
                    end
                end
                S_RSP_GAP: if (gap_zero) state <= S_RSP_RD;
                default:   state <= S_IDLE;
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign result   = res_q;
    assign mb_rd_en = (state == S_OWN_RD) || (state == S_RSP_RD);
    assign mb_wr_en = (state == S_SEND);
    assign mb_addr  = mb_wr_en ? widx : 3'(HDR_WORD);
    assign mb_wdata = image[{widx, 5'd0} +: 32];
endmodule

// File: rtl/mbx_req_chk.sv
module mbx_req_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [1:0]  result,
    input logic        mb_rd_en,
    input logic        mb_wr_en,
    input logic [2:0]  mb_addr,
    input logic [31:0] mb_wdata
);
    AST_RD_HDR_ONLY: assert property (@(posedge clk) disable iff (rst)
        mb_rd_en |-> mb_addr == 3'd7);  // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mb_rd_en && !mb_wr_en);  // R2
    AST_BADARG_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd1) |-> !$past(busy));  // R2
    AST_HDR_REQ_DIR: assert property (@(posedge clk) disable iff (rst)
        (mb_wr_en && mb_addr == 3'd7) |-> (!mb_wdata[7] && !mb_wdata[31]));  // R5
    AST_WR_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (mb_wr_en && mb_addr != 3'd7) |=> (mb_wr_en && mb_addr == $past(mb_addr) + 3'd1));  // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R11
endmodule

bind mbx_req_engine mbx_req_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .result(result),
    .mb_rd_en(mb_rd_en), .mb_wr_en(mb_wr_en), .mb_addr(mb_addr), .mb_wdata(mb_wdata)
);

// File: tb/mbx_req_engine_tb.sv
module mbx_req_engine_tb;
    localparam int LIM = 5;
    localparam int GAP = 3;

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_kind = 0, cmd_reset = 0;
    logic [63:0] eq_addr = 0, cq_addr = 0, rq_addr = 0, sq_addr = 0;
    logic [31:0] vec_idx = 0;
    logic busy, done, mb_rd_en, mb_wr_en;
    logic [1:0] result;
    logic [2:0] mb_addr;
    logic [31:0] mb_wdata, mb_rdata;

    always #2 clk = ~clk;

    mbx_req_engine #(.POLL_LIMIT(LIM), .POLL_GAP(GAP)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_reset(cmd_reset), .eq_addr(eq_addr), .cq_addr(cq_addr),
        .rq_addr(rq_addr), .sq_addr(sq_addr), .vec_idx(vec_idx),
        .busy(busy), .done(done), .result(result), .mb_rd_en(mb_rd_en),
        .mb_wr_en(mb_wr_en), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
        .mb_rdata(mb_rdata)
    );

    // mailbox and responder model
    logic        ld7 = 0, clr_log = 0, rsp_en = 0;
    logic [31:0] ld7_val = 0, rsp_word = 0;
    int          rsp_delay = 0;
    logic [31:0] mem [8];
    logic [2:0]  w_a [16];
    logic [31:0] w_d [16];
    int          w_t [16];
    int          wn = 0, rd_n = 0, dn_n = 0, cyc = 0, rcnt = 0;
    logic        armed = 0;

    initial for (int i = 0; i < 8; i++) mem[i] = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mb_rd_en) mb_rdata <= mem[mb_addr];
        if (clr_log) begin
            wn <= 0; rd_n <= 0; dn_n <= 0; armed <= 0;
        end else begin
            if (mb_rd_en) rd_n <= rd_n + 1;
            if (done) dn_n <= dn_n + 1;
            if (mb_wr_en && wn < 16) begin
                w_a[wn] <= mb_addr; w_d[wn] <= mb_wdata; w_t[wn] <= cyc; wn <= wn + 1;
            end
        end
        if (ld7) mem[7] <= ld7_val;
        else if (mb_wr_en) begin
            mem[mb_addr] <= (mb_addr == 3'd7) ? (mb_wdata | 32'h8000_0000) : mb_wdata;
            if (mb_addr == 3'd7) begin armed <= 1; rcnt <= rsp_delay; end
        end else if (armed) begin
            if (rcnt == 0) begin
                if (rsp_en) mem[7] <= rsp_word;
                armed <= 0;
            end else rcnt <= rcnt - 1;
        end
    end

    int errors = 0, checks = 0;
    logic [63:0] ta [4];
    logic [15:0] tv;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int k, logic kind, logic rf);
        logic [7:0] b [32];
        logic [15:0] hi;
        logic [63:0] fr;
        hi = 0;
        for (int i = 0; i < 4; i++) begin
            fr = ta[i] >> 12;
            for (int j = 0; j < 6; j++) b[6*i+j] = fr[8*j +: 8];
            hi = hi | (16'(fr[51:48]) << (4*i));
        end
        b[24] = hi[7:0];  b[25] = hi[15:8];
        b[26] = tv[7:0];  b[27] = tv[15:8];
        b[28] = kind ? 8'd2 : 8'd1;
        b[29] = 0; b[30] = 0;
        b[31] = rf ? 8'h01 : 8'h00;
        return {b[4*k+3], b[4*k+2], b[4*k+1], b[4*k]};
    endfunction

    function automatic logic [31:0] mk_reply(logic [2:0] t, logic [2:0] v, logic d, logic [7:0] s);
        return {16'd0, s, d, 1'b0, v, t};
    endfunction

    // runs one command; hold<0 never releases the mailbox before sending
    task automatic run(input logic kind, input logic rf, input logic [31:0] vec,
                       input logic [31:0] pre7, input int hold, input logic ren,
                       input logic [31:0] rword, input logic poke, output logic [1:0] res);
        int c;
        logic seen;
        @(negedge clk);
        ld7 = 1; ld7_val = pre7; clr_log = 1;
        rsp_en = ren; rsp_word = rword; rsp_delay = 7;
        @(negedge clk);
        ld7 = 0; clr_log = 0;
        cmd_valid = 1; cmd_kind = kind; cmd_reset = rf;
        eq_addr = ta[0]; cq_addr = ta[1]; rq_addr = ta[2]; sq_addr = ta[3]; vec_idx = vec;
        c = 0; seen = 0; res = 0;
        while (!seen && c < 2000) begin
            @(negedge clk);
            c++;
            cmd_valid = poke && (c == 3);
            if (poke && c == 3) cmd_kind = 1;
            if (c == hold) begin ld7 = 1; ld7_val = pre7 & 32'h7FFF_FFFF; end
            else ld7 = 0;
            if (done) begin seen = 1; res = result; end
        end
        ld7 = 0; cmd_valid = 0;
        if (!seen) begin
            errors++; checks++;
            $display("FAIL R11 watchdog actual=no_done expected=done");
        end
    endtask

    task automatic check_est_words(input logic rf, input string tag);
        chk(wn == 8, {tag, " R6 write count"}, wn, 8);
        for (int k = 0; k < 8 && k < wn; k++) begin
            chk(w_a[k] == 3'(k), {tag, " R6 order"}, w_a[k], k);
            chk(w_d[k] == exp_word(k, 1'b0, rf), {tag, " R3 R4 R5 word"}, w_d[k], exp_word(k, 1'b0, rf));
            if (k > 0) chk(w_t[k] == w_t[k-1] + 1, {tag, " R6 back to back"}, w_t[k], w_t[k-1] + 1);
        end
    endtask

    logic [1:0] r;
    logic [31:0] good_e, good_d;

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                while (wd < 150000) begin @(posedge clk); wd++; end
                errors++; checks++;
                $display("FAIL R11 global watchdog actual=hung expected=finish");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none
        void'($urandom(1234));
        good_e = mk_reply(3'd1, 3'd0, 1'b1, 8'd0);
        good_d = mk_reply(3'd2, 3'd0, 1'b1, 8'd0);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !mb_wr_en && !mb_rd_en, "R11 reset state", {busy, done, mb_wr_en, mb_rd_en}, 0);

        // random establish with varied replies
        for (int n = 0; n < 24; n++) begin
            logic rf;
            logic [2:0] rt, rv;
            logic rdir;
            logic [7:0] rs;
            logic [1:0] er;
            for (int i = 0; i < 4; i++) ta[i] = {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_F000;
            ta[n % 4][63:60] = 4'hF - 4'(n % 4);
            tv = 16'($urandom);
            rf = 1'($urandom);
            rt = 3'd1; rv = 3'd0; rdir = 1; rs = 0;
            case (n % 6)
                1: rt = 3'd2;
                2: rv = 3'd1;
                3: rdir = 0;
                4: rs = 8'($urandom % 255 + 1);
                default: ;
            endcase
            er = (rt == 1 && rv == 0 && rdir && rs == 0) ? 2'd0 : 2'd3;
            run(1'b0, rf, {16'd0, tv}, 32'h8000_0000, (n % 3) * 4 + 1, 1'b1,
                mk_reply(rt, rv, rdir, rs), 1'b0, r);
            chk(r == er, "R10 reply verdict", r, er);
            chk(rd_n >= 2, "R1 polled before send", rd_n, 2);
            check_est_words(rf, "est");
        end

        // destroy ignores address and vector inputs
        ta[0] = 64'h123; ta[1] = 64'h5; ta[2] = 0; ta[3] = 64'hFFF; tv = 0;
        run(1'b1, 1'b1, 32'hABCD_0000, 32'h0, -1, 1'b1, good_d, 1'b0, r);
        chk(r == 2'd0, "R7 destroy result", r, 0);
        chk(wn == 1 && w_a[0] == 3'd7, "R7 single header write", {wn, w_a[0]}, {32'd1, 3'd7});
        chk(w_d[0] == 32'h0100_0002, "R5 R7 destroy header", w_d[0], 32'h0100_0002);

        // bad arguments
        for (int i = 0; i < 4; i++) ta[i] = 64'h1000 * (i + 1);
        ta[2] = ta[2] | 64'h800;
        run(1'b0, 1'b0, 32'h10, 32'h0, -1, 1'b1, good_e, 1'b0, r);
        chk(r == 2'd1, "R2 misaligned result", r, 1);
        chk(wn == 0 && rd_n == 0, "R2 misaligned untouched", {wn, rd_n}, 0);
        ta[2] = 64'h3000;
        run(1'b0, 1'b0, 32'h0001_0000, 32'h0, -1, 1'b1, good_e, 1'b0, r);
        chk(r == 2'd1, "R2 wide vector result", r, 1);
        chk(wn == 0 && rd_n == 0, "R2 wide vector untouched", {wn, rd_n}, 0);
        tv = 16'hFFFF;
        run(1'b0, 1'b0, 32'h0000_FFFF, 32'h0, -1, 1'b1, good_e, 1'b0, r);
        chk(r == 2'd0, "R2 max vector accepted", r, 0);
        check_est_words(1'b0, "maxvec");

        // timeout before sending
        run(1'b0, 1'b0, 32'hFFFF, 32'h8000_0000, -1, 1'b1, good_e, 1'b0, r);
        chk(r == 2'd2, "R8 pre timeout result", r, 2);
        chk(rd_n == LIM && wn == 0, "R8 pre timeout reads", {rd_n, wn}, {32'(LIM), 32'd0});
        chk(mem[7] == 32'h8000_0000, "R1 header untouched while not owned", mem[7], 32'h8000_0000);

        // timeout waiting for reply
        run(1'b0, 1'b0, 32'hFFFF, 32'h0, -1, 1'b0, good_e, 1'b0, r);
        chk(r == 2'd2, "R8 reply timeout result", r, 2);
        chk(rd_n == LIM + 1, "R8 reply timeout reads", rd_n, LIM + 1);

        // all-ones reply with and without reset flag
        run(1'b0, 1'b1, 32'hFFFF, 32'h0, -1, 1'b1, 32'hFFFF_FFFF, 1'b0, r);
        chk(r == 2'd0, "R9 all ones with reset", r, 0);
        run(1'b1, 1'b0, 32'h0, 32'h0, -1, 1'b1, 32'hFFFF_FFFF, 1'b0, r);
        chk(r == 2'd2, "R9 all ones without reset", r, 2);

        // command while busy is ignored
        run(1'b0, 1'b0, 32'hFFFF, 32'h0, -1, 1'b1, good_e, 1'b1, r);
        repeat (6) @(negedge clk);
        chk(r == 2'd0, "R11 busy poke result", r, 0);
        chk(dn_n == 1, "R11 one done pulse", dn_n, 1);
        check_est_words(1'b0, "poke R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule